// File: doc/BRIEF.md
# Rotating Priority Resolver

This block decides which of eight interrupt lines, if any, an interrupt controller should present to the processor. It is purely combinational. It takes the current request, mask and in-service vectors along with a rotation offset and two mode flags. It returns a valid flag and the encoded number of the winning line. The surrounding controller owns every register. This block only arbitrates.

Priority is circular. Priority level p belongs to line (p + offset) mod 8, and level 0 is the strongest. Requests whose mask bit is set are not candidates. The strongest remaining candidate is compared with the strongest line already in service. It is offered only if its level is strictly lower. On the cascade master, a special nested mode can hide the cascade input (line 2) from the in-service comparison, so that a second request from a downstream controller can nest on top of one already being serviced.

The house style's state machine does not apply, because the block holds no state. The datapath has four stages in order:
- **MASK**: clear the masked requests and, when nested mode is on the master, the cascade bit of the in-service vector.
- **ALIGN**: rotate both vectors so that bit 0 is level 0.
- **PICK**: find the lowest set level of each vector.
- **RESTORE**: compare the two levels, then rotate the winning bit back and encode it.

Top module: `rot_prio_resolver`

## Requirements
- R1: A request line whose mask bit is 1 is never reported. The candidates are `req_vec & ~mask_vec`.
- R2: Level p corresponds to line (p + `rot_ofs`) mod 8, and level 0 ranks highest. Of several candidates, the one with the lowest level is reported.
- R3: With no candidate, `irq_valid` is 0.
- R4: An empty in-service vector counts as level 8, which is weaker than any real level. `irq_valid` is 1 only when the best candidate's level is strictly lower than the best in-service level. Equal or higher gives 0.
- R5: When `nest_special` and `is_master` are both 1, in-service bit 2 is left out of the comparison. All other in-service bits still count.
- R6: When `is_master` is 0, `nest_special` has no effect on the outputs. When `nest_special` is 0, in-service bit 2 counts like any other bit.
- R7: When `irq_valid` is 1, `irq_line` is (winning level + `rot_ofs`) mod 8, in binary. Both outputs follow the inputs with no clock cycle of delay. `irq_line` carries no meaning while `irq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_vec | input | 8 | Pending request bits, bit n for line n |
| mask_vec | input | 8 | Mask bits; 1 blocks the line |
| svc_vec | input | 8 | Lines currently in service |
| rot_ofs | input | 3 | Rotation offset: line holding level 0 |
| nest_special | input | 1 | Special nested mode enable |
| is_master | input | 1 | Instance is the cascade master |
| irq_valid | output | 1 | A line should be presented |
| irq_line | output | 3 | Encoded winning line |

## Verification
Both results are due in the same time step as the stimulus, with zero clock cycles of delay, because no register lies on any path. The bench drives a full input set and waits one time unit for the logic to settle. It then compares `irq_valid` and, when a line is expected, `irq_line` against an arithmetic model of the level search. Nothing is ever sampled at a clock edge. The sweep covers every request pattern under every offset, several mask and in-service patterns, and all four mode-flag combinations.

// File: rtl/prio_pkg.sv
package prio_pkg;
    // Default arbitration width; must be a power of two for modular rotation.
    localparam int DEF_LINES   = 8;
    // Line number that carries the downstream controller on a master.
    localparam int DEF_CASCADE = 2;
endpackage

// File: rtl/prio_rotate.sv
// Circular rotation of a request-style vector by a line offset.
// INVERSE=0: out[p] = in[(p + ofs) mod LINES]   (physical -> level order)
// INVERSE=1: out[l] = in[(l - ofs) mod LINES]   (level -> physical order)
module prio_rotate #(
    parameter int LINES   = prio_pkg::DEF_LINES,
    parameter bit INVERSE = 1'b0,
    localparam int IDX_W  = $clog2(LINES)
) (
    input  logic [LINES-1:0] vec_i,
    input  logic [IDX_W-1:0] ofs_i,
    output logic [LINES-1:0] vec_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_bit
        localparam logic [IDX_W-1:0] POS = IDX_W'(g);
        logic [IDX_W-1:0] src;
        if (INVERSE) begin : g_inv
            assign src = POS - ofs_i;
        end else begin : g_fwd
            assign src = POS + ofs_i;
        end
        assign vec_o[g] = vec_i[src];
    end
endmodule

// File: rtl/prio_first.sv
// Lowest set bit position of a level-ordered vector; LINES when empty.
module prio_first #(
    parameter int LINES  = prio_pkg::DEF_LINES,
    localparam int LVL_W = $clog2(LINES) + 1
) (
    input  logic [LINES-1:0] vec_i,
    output logic [LVL_W-1:0] level_o
);
    always_comb begin
        level_o = LVL_W'(LINES);
        for (int i = LINES - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                level_o = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_encode.sv
// Binary encode of a vector holding at most one set bit.
module prio_encode #(
    parameter int LINES  = prio_pkg::DEF_LINES,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] hot_i,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < LINES; i++) begin
            if (hot_i[i]) begin
                idx_o = idx_o | IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rot_prio_resolver.sv
// Combinational rotating-priority interrupt arbiter.
module rot_prio_resolver #(
    parameter int LINES        = prio_pkg::DEF_LINES,
    parameter int CASCADE_LINE = prio_pkg::DEF_CASCADE,
    localparam int IDX_W       = $clog2(LINES),
    localparam int LVL_W       = IDX_W + 1
) (
    input  logic [LINES-1:0] req_vec,
    input  logic [LINES-1:0] mask_vec,
    input  logic [LINES-1:0] svc_vec,
    input  logic [IDX_W-1:0] rot_ofs,
    input  logic             nest_special,
    input  logic             is_master,
    output logic             irq_valid,
    output logic [IDX_W-1:0] irq_line
);
    localparam logic [LINES-1:0] CASCADE_BIT = LINES'(1) << CASCADE_LINE;

    // MASK stage
    logic [LINES-1:0] cand_phys;
    logic [LINES-1:0] svc_phys;
    logic             hide_cascade;

    assign hide_cascade = nest_special & is_master;
    assign cand_phys    = req_vec & ~mask_vec;
    assign svc_phys     = svc_vec & ~(hide_cascade ? CASCADE_BIT : '0);

    // ALIGN stage
    logic [LINES-1:0] cand_lvl;
    logic [LINES-1:0] svc_lvl;

    prio_rotate #(.LINES(LINES), .INVERSE(1'b0)) i_rot_cand (
        .vec_i(cand_phys), .ofs_i(rot_ofs), .vec_o(cand_lvl)
    );
    prio_rotate #(.LINES(LINES), .INVERSE(1'b0)) i_rot_svc (
        .vec_i(svc_phys), .ofs_i(rot_ofs), .vec_o(svc_lvl)
    );

    // PICK stage
    logic [LVL_W-1:0] cand_best;
    logic [LVL_W-1:0] svc_best;

    prio_first #(.LINES(LINES)) i_pick_cand (.vec_i(cand_lvl), .level_o(cand_best));
    prio_first #(.LINES(LINES)) i_pick_svc  (.vec_i(svc_lvl),  .level_o(svc_best));

    // RESTORE stage
    logic [LINES-1:0] win_lvl_hot;
    logic [LINES-1:0] win_phys_hot;

    assign win_lvl_hot = cand_lvl & (~cand_lvl + LINES'(1));

    prio_rotate #(.LINES(LINES), .INVERSE(1'b1)) i_rot_back (
        .vec_i(win_lvl_hot), .ofs_i(rot_ofs), .vec_o(win_phys_hot)
    );
    prio_encode #(.LINES(LINES)) i_enc (.hot_i(win_phys_hot), .idx_o(irq_line));

    // An empty candidate vector yields level LINES, which never beats svc_best.
    assign irq_valid = (cand_best < svc_best);
endmodule

// File: rtl/rot_prio_resolver_chk.sv
// Port-level invariants of the resolver, attached by bind.
module rot_prio_resolver_chk #(
    parameter int LINES        = prio_pkg::DEF_LINES,
    parameter int CASCADE_LINE = prio_pkg::DEF_CASCADE,
    localparam int IDX_W       = $clog2(LINES)
) (
    input logic [LINES-1:0] req_vec,
    input logic [LINES-1:0] mask_vec,
    input logic [LINES-1:0] svc_vec,
    input logic [IDX_W-1:0] rot_ofs,
    input logic             nest_special,
    input logic             is_master,
    input logic             irq_valid,
    input logic [IDX_W-1:0] irq_line
);
    logic [LINES-1:0] cand;
    logic             line_is_cascade;
    assign cand            = req_vec & ~mask_vec;
    assign line_is_cascade = (irq_line == IDX_W'(CASCADE_LINE));

    always_comb begin
        if (irq_valid) begin
            assert_reported_unmasked_R1: assert (cand[irq_line])
                else $error("reported line is masked or not requested");
        end
        if (cand == '0) begin
            assert_idle_when_empty_R3: assert (!irq_valid)
                else $error("valid raised with no candidate");
        end
        if (svc_vec == '0 && cand != '0) begin
            assert_empty_service_wins_R4: assert (irq_valid)
                else $error("candidate lost against empty service");
        end
        if (irq_valid && !(nest_special && is_master && line_is_cascade)) begin
            assert_no_self_preempt_R5: assert (!svc_vec[irq_line])
                else $error("line already in service reported again");
        end
    end
    // rot_ofs is read only to keep every resolver input visible here.
    logic unused_ofs;
    assign unused_ofs = ^rot_ofs;
endmodule

bind rot_prio_resolver rot_prio_resolver_chk #(
    .LINES(LINES), .CASCADE_LINE(CASCADE_LINE)
) i_rot_prio_resolver_chk (
    .req_vec(req_vec), .mask_vec(mask_vec), .svc_vec(svc_vec),
    .rot_ofs(rot_ofs), .nest_special(nest_special), .is_master(is_master),
    .irq_valid(irq_valid), .irq_line(irq_line)
);

// File: tb/test_rot_prio_resolver.sv
module test_rot_prio_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic [7:0] req_vec, mask_vec, svc_vec;
    logic [2:0] rot_ofs;
    logic       nest_special, is_master;
    logic       irq_valid;
    logic [2:0] irq_line;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    rot_prio_resolver i_rot_prio_resolver (
        .req_vec(req_vec), .mask_vec(mask_vec), .svc_vec(svc_vec),
        .rot_ofs(rot_ofs), .nest_special(nest_special), .is_master(is_master),
        .irq_valid(irq_valid), .irq_line(irq_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycles %0d expected below %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
            $finish;
        end
    end

    // Arithmetic model from the requirements.
    function automatic void model(input logic [7:0] rq, mk, sv, input int ofs,
                                  input logic ns, ms, output logic v, output int line);
        logic [7:0] c, s;
        int pl, sl;
        c = rq & ~mk;
        s = sv;
        if (ns && ms) s[2] = 1'b0;
        pl = 8; sl = 8;
        for (int p = 7; p >= 0; p--) begin
            if (c[(p + ofs) % 8]) pl = p;
            if (s[(p + ofs) % 8]) sl = p;
        end
        v = (pl < sl);
        line = (pl + ofs) % 8;
    endfunction

    task automatic apply(input logic [7:0] rq, mk, sv, input int ofs, input logic ns, ms);
        req_vec = rq; mask_vec = mk; svc_vec = sv; rot_ofs = 3'(ofs);
        nest_special = ns; is_master = ms;
        #1;
    endtask

    // Compare outputs with explicit expectation.
    task automatic expect_out(input string tag, input logic ev, input int el);
        n_cmp = n_cmp + 1;
        if (irq_valid !== ev || (ev && int'(irq_line) != el)) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual valid=%0b line=%0d expected valid=%0b line=%0d (req=%h mask=%h svc=%h ofs=%0d ns=%0b m=%0b)",
                     tag, irq_valid, irq_line, ev, el, req_vec, mask_vec, svc_vec, rot_ofs, nest_special, is_master);
        end
    endtask

    task automatic check_model(input string tag);
        logic ev; int el;
        model(req_vec, mask_vec, svc_vec, int'(rot_ofs), nest_special, is_master, ev, el);
        expect_out(tag, ev, el);
    endtask

    initial begin
        logic [7:0] svc_set [11];
        logic [7:0] mask_set [3];
        svc_set[0] = 8'h00; svc_set[9] = 8'h05; svc_set[10] = 8'hFF;
        for (int i = 0; i < 8; i++) svc_set[i+1] = 8'(1 << i);
        mask_set[0] = 8'h00; mask_set[1] = 8'hA5; mask_set[2] = 8'h3C;

        // Idle inputs: nothing offered (R3).
        apply(8'h00, 8'h00, 8'h00, 0, 1'b0, 1'b0);
        expect_out("R3 idle", 1'b0, 0);

        // R1: masked request ignored, unmasked lower-priority one wins.
        apply(8'h09, 8'h01, 8'h00, 0, 1'b0, 1'b0);
        expect_out("R1 mask skips line0", 1'b1, 3);
        apply(8'hFF, 8'hFF, 8'h00, 0, 1'b0, 1'b0);
        expect_out("R1 all masked", 1'b0, 0);

        // R2: rotation offset 5 makes line 5 strongest, line 4 weakest.
        apply(8'h30, 8'h00, 8'h00, 5, 1'b0, 1'b0);
        expect_out("R2 ofs5 picks line5", 1'b1, 5);
        apply(8'h11, 8'h00, 8'h00, 5, 1'b0, 1'b0);
        expect_out("R2 ofs5 wraps to line0", 1'b1, 0);

        // R4: equal level does not win; strictly better does.
        apply(8'h08, 8'h00, 8'h08, 0, 1'b0, 1'b0);
        expect_out("R4 equal level blocked", 1'b0, 0);
        apply(8'h02, 8'h00, 8'h08, 0, 1'b0, 1'b0);
        expect_out("R4 higher preempts", 1'b1, 1);
        apply(8'h20, 8'h00, 8'h08, 0, 1'b0, 1'b0);
        expect_out("R4 lower blocked", 1'b0, 0);

        // R5: nested master ignores in-service line 2.
        apply(8'h04, 8'h00, 8'h04, 0, 1'b1, 1'b1);
        expect_out("R5 cascade renests", 1'b1, 2);
        apply(8'h10, 8'h00, 8'h06, 0, 1'b1, 1'b1);
        expect_out("R5 other bits still count", 1'b0, 0);

        // R6: the flag is inert on a non-master; bit 2 counts with flag off.
        apply(8'h04, 8'h00, 8'h04, 0, 1'b1, 1'b0);
        expect_out("R6 non-master ignores flag", 1'b0, 0);
        apply(8'h04, 8'h00, 8'h04, 0, 1'b0, 1'b1);
        expect_out("R6 flag off bit2 counts", 1'b0, 0);

        // R7: line encoding across every offset with a single request at line 7.
        for (int o = 0; o < 8; o++) begin
            apply(8'h80, 8'h00, 8'h00, o, 1'b0, 1'b0);
            expect_out("R7 encode line7", 1'b1, 7);
        end

        // Sweep: every request pattern, offset, flag pair, several masks and services (R2 R4 R7).
        for (int f = 0; f < 4; f++) begin
            for (int m = 0; m < 3; m++) begin
                for (int s = 0; s < 11; s++) begin
                    for (int o = 0; o < 8; o++) begin
                        for (int r = 0; r < 256; r++) begin
                            apply(8'(r), mask_set[m], svc_set[s], o, f[1], f[0]);
                            check_model("R2/R4/R7 sweep");
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule